// File: doc/BRIEF.md
# Output Phase Slope Limiter

This block takes a phase offset that shows up when the timing source is switched or the operating mode changes, and releases it to an output timing generator a little at a time. Each event delivers a signed step in nanoseconds. The step is added to a pending residual. On every 125 µs frame strobe the block moves a bounded slice of that residual into a per-frame correction and into a running accumulated offset. Because of this, the output phase moves smoothly and never jumps.

Each frame releases at most 5 ns, which keeps the slope well under 7.6 ns per frame. The pending residual is never allowed to exceed ±200 ns. When a step, or a step added on top of a residual still draining, would exceed that bound, the residual saturates and a sticky flag records the event. A busy output shows that a residual is still being released.

Top module: `phase_slope_limiter`

## Requirements
- R1: After reset the correction, the accumulated offset and the residual are zero, and busy and the clamp flag are low.
- R2: On a frame strobe, the correction output becomes sign(residual)·min(|residual|, 5) in the following cycle and holds until the next frame strobe. A frame strobe with no residual gives a correction of 0.
- R3: On every frame strobe, the accumulated offset changes by exactly the correction applied in that frame, and the residual changes by its negative.
- R4: An event adds its step to the residual. The result saturates at +200 or −200 ns.
- R5: An event arriving while a residual is pending adds to whatever remains. If a frame strobe falls in the same cycle, that frame's slice is removed first.
- R6: Busy is high while the residual is nonzero. It goes low in the cycle after the frame strobe that brings the residual to zero.
- R7: The clamp flag is set whenever an event saturates the residual. It stays set until reset.
- R8: The magnitude of the correction output never exceeds 5 ns.
- R9: An event whose step is zero leaves the residual, busy and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStb | input | 1 | One-cycle strobe per 125 µs frame |
| eventStb | input | 1 | One-cycle strobe on a source switch or mode change |
| stepIn | input | STEP_W | Signed phase step in ns, valid with eventStb |
| corrOut | output | CORR_W | Signed correction for the current frame, in ns |
| accumOut | output | ACC_W | Signed running sum of all corrections, in ns |
| busy | output | 1 | Residual still pending |
| clampFlag | output | 1 | Sticky: a step was saturated |

## Verification
The assertions assume that both strobes last one cycle and are low while reset is applied. They also assume that stepIn matters only in cycles where eventStb is high. The driver task changes inputs only on the falling clock edge and raises each strobe for exactly one cycle. It also returns both strobes to zero on idle cycles. Some stimulus places a frame strobe and an event in the same cycle on purpose, so the same-cycle order is exercised with legal input.

// File: rtl/phase_slope_pkg.sv
package phase_slope_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic frameTick;
    logic eventLoad;
  } ctrlStb_t;
endpackage

// File: rtl/pslim_ctrl.sv
module pslim_ctrl
  import phase_slope_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameStb,
  input  logic     eventStb,
  input  logic     stepIsZero,
  input  logic     resNonZero,
  output ctrlStb_t stb,
  output logic     busy
);
  // a zero step carries no offset: do not load it (R9)
  always_comb begin
    stb.frameTick = frameStb;
    stb.eventLoad = eventStb && !stepIsZero;
  end

  assign busy = resNonZero;

  // R6: when idle and nothing arrives, stay idle
  a_r6_idle_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !eventStb) |=> !busy);

  // R9: a zero step never reaches the datapath
  a_r9_zero_step_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (eventStb && stepIsZero) |-> !stb.eventLoad);
endmodule

// File: rtl/pslim_datapath.sv
module pslim_datapath
  import phase_slope_pkg::*;
#(
  parameter int STEP_W    = 12,
  parameter int ACC_W     = 20,
  parameter int MAX_SLOPE = 5,
  parameter int MAX_PEND  = 200,
  localparam int RES_W    = $clog2(MAX_PEND + 1) + 1,
  localparam int CORR_W   = $clog2(MAX_SLOPE + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStb_t                 stb,
  input  logic signed [STEP_W-1:0] stepIn,
  output logic signed [CORR_W-1:0] corrOut,
  output logic signed [ACC_W-1:0]  accumOut,
  output logic                     resNonZero,
  output logic                     clampFlag
);
  localparam int SUM_W = ((STEP_W > RES_W) ? STEP_W : RES_W) + 1;
  localparam logic signed [SUM_W-1:0] PEND_S = SUM_W'(MAX_PEND);
  localparam logic signed [RES_W-1:0] PEND_R = RES_W'(MAX_PEND);
  localparam logic [RES_W-1:0]        SLOPE_R = RES_W'(MAX_SLOPE);

  logic signed [RES_W-1:0] residual;
  logic [RES_W-1:0]        resAbs;
  logic [RES_W-1:0]        sliceMag;
  logic signed [RES_W-1:0] slice;
  logic signed [RES_W-1:0] afterFrame;
  logic signed [SUM_W-1:0] sum;
  logic                    overPos;
  logic                    overNeg;
  logic signed [RES_W-1:0] resNext;

  // slice released this frame: residual limited to the slope bound
  always_comb begin
    resAbs   = residual[RES_W-1] ? RES_W'(-residual) : RES_W'(residual);
    sliceMag = (resAbs > SLOPE_R) ? SLOPE_R : resAbs;
    slice    = residual[RES_W-1] ? -$signed(sliceMag) : $signed(sliceMag);
  end

  // frame slice first, then the event is added and saturated
  always_comb begin
    afterFrame = stb.frameTick ? (residual - slice) : residual;
    sum        = SUM_W'(afterFrame) + SUM_W'(stepIn);
    overPos    = sum > PEND_S;
    overNeg    = sum < -PEND_S;
    if (!stb.eventLoad)  resNext = afterFrame;
    else if (overPos)    resNext = PEND_R;
    else if (overNeg)    resNext = -PEND_R;
    else                 resNext = RES_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      residual  <= '0;
      corrOut   <= '0;
      accumOut  <= '0;
      clampFlag <= 1'b0;
    end else begin
      residual <= resNext;
      if (stb.frameTick) begin
        corrOut  <= CORR_W'(slice);
        accumOut <= accumOut + ACC_W'(slice);
      end
      if (stb.eventLoad && (overPos || overNeg)) clampFlag <= 1'b1;
    end
  end

  assign resNonZero = (residual != '0);

  // residual plus accumulated offset is conserved by a frame step
  logic signed [ACC_W-1:0] ledger;
  assign ledger = accumOut + ACC_W'(residual);

  // R3
  a_r3_frame_conserves: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameTick && !stb.eventLoad) |=> $stable(ledger));

  // R8
  a_r8_slope_bound: assert property (@(posedge clk) disable iff (!rstN)
    (corrOut <= CORR_W'(MAX_SLOPE)) && (corrOut >= -CORR_W'(MAX_SLOPE)));

  // R4
  a_r4_pend_bound: assert property (@(posedge clk) disable iff (!rstN)
    (residual <= PEND_R) && (residual >= -PEND_R));

  // R7
  a_r7_clamp_sticky: assert property (@(posedge clk) disable iff (!rstN)
    clampFlag |=> clampFlag);

  // R2: correction only moves on a frame strobe
  a_r2_corr_held: assert property (@(posedge clk) disable iff (!rstN)
    !stb.frameTick |=> $stable(corrOut) && $stable(accumOut));

  // R9: no strobe, no change to the residual
  a_r9_quiet_residual: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.frameTick && !stb.eventLoad) |=> $stable(residual));
endmodule

// File: rtl/phase_slope_limiter.sv
module phase_slope_limiter
  import phase_slope_pkg::*;
#(
  parameter int STEP_W    = 12,
  parameter int ACC_W     = 20,
  parameter int MAX_SLOPE = 5,
  parameter int MAX_PEND  = 200,
  localparam int CORR_W   = $clog2(MAX_SLOPE + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameStb,
  input  logic                     eventStb,
  input  logic signed [STEP_W-1:0] stepIn,
  output logic signed [CORR_W-1:0] corrOut,
  output logic signed [ACC_W-1:0]  accumOut,
  output logic                     busy,
  output logic                     clampFlag
);
  ctrlStb_t stb;
  logic     resNonZero;
  logic     stepIsZero;

  assign stepIsZero = (stepIn == '0);

  pslim_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameStb   (frameStb),
    .eventStb   (eventStb),
    .stepIsZero (stepIsZero),
    .resNonZero (resNonZero),
    .stb        (stb),
    .busy       (busy)
  );

  pslim_datapath #(
    .STEP_W    (STEP_W),
    .ACC_W     (ACC_W),
    .MAX_SLOPE (MAX_SLOPE),
    .MAX_PEND  (MAX_PEND)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .stepIn     (stepIn),
    .corrOut    (corrOut),
    .accumOut   (accumOut),
    .resNonZero (resNonZero),
    .clampFlag  (clampFlag)
  );
endmodule

// File: tb/phase_slope_limiter_tb_top.sv
module phase_slope_limiter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 1'b0;
  logic eventStb = 1'b0;
  logic signed [11:0] stepIn = '0;
  logic signed [3:0]  corrOut;
  logic signed [19:0] accumOut;
  logic busy;
  logic clampFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  phase_slope_limiter dut_i (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .eventStb(eventStb),
    .stepIn(stepIn), .corrOut(corrOut), .accumOut(accumOut),
    .busy(busy), .clampFlag(clampFlag)
  );

  typedef struct {
    int    corr;
    int    acc;
    bit    bsy;
    bit    clmp;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference model state
  int mRes = 0, mAcc = 0, mCorr = 0;
  bit mClamp = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus plus its expected result
  task automatic cyc(bit fr, bit ev, int step, string tag);
    expItem_t it;
    int a;
    @(negedge clk);
    frameStb = fr;
    eventStb = ev;
    stepIn   = 12'(step);
    if (fr) begin
      a = (mRes > 5) ? 5 : (mRes < -5) ? -5 : mRes;
      mRes -= a;
      mAcc += a;
      mCorr = a;
    end
    if (ev && step != 0) begin
      mRes += step;
      if (mRes > 200) begin mRes = 200; mClamp = 1; end
      else if (mRes < -200) begin mRes = -200; mClamp = 1; end
    end
    it.corr = mCorr; it.acc = mAcc; it.bsy = (mRes != 0);
    it.clmp = mClamp; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    frameStb = 0; eventStb = 0; stepIn = '0;
  endtask

  // monitor: compare after each edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        chk(it.tag, "corrOut", int'(corrOut), it.corr);
        chk(it.tag, "accumOut", int'(accumOut), it.acc);
        chk(it.tag, "busy", int'(busy), int'(it.bsy));
        chk(it.tag, "clampFlag", int'(clampFlag), int'(it.clmp));
      end
    end
  end

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "corrOut", int'(corrOut), 0);
    chk("R1", "accumOut", int'(accumOut), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "clampFlag", int'(clampFlag), 0);

    cyc(1, 0, 0, "R2 idle frame");
    cyc(0, 1, 0, "R9 zero step");
    cyc(1, 0, 0, "R9 frame after zero step");

    cyc(0, 1, 23, "R4 step +23");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, "R2 R3 R6 drain +23");
    cyc(0, 1, -12, "R4 step -12");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, "R2 R8 drain -12");

    cyc(0, 1, 150, "R4 step 150");
    cyc(1, 0, 0, "R3 frame");
    cyc(1, 0, 0, "R3 frame");
    cyc(0, 1, 40, "R5 add while pending");
    cyc(1, 1, 7, "R5 frame and event same cycle");
    cyc(0, 1, 100, "R7 combined clamp");
    for (int i = 0; i < 42; i++) cyc(1, 0, 0, "R6 R8 drain 200");

    cyc(0, 1, -500, "R4 R7 step -500");
    cyc(0, 0, 0, "R2 hold between frames");
    for (int i = 0; i < 41; i++) cyc(1, 0, 0, "R3 R6 drain -200");
    cyc(0, 1, 0, "R9 zero step idle");
    idle();
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule